// File: doc/BRIEF.md
# Two-Wire Transition-Signalling Serial Transmitter

This block serialises parallel words onto a pair of wires. A bit is carried by which wire changes level, not by the level itself. A toggle on the zero wire means a 0 and a toggle on the one wire means a 1. Exactly one wire changes for each bit, so the XOR of the two wires flips once per bit. A receiver can use that XOR as a strobe and capture on both of its edges.

Words enter through a valid/ready handshake and leave most significant bit first, one bit for each cycle in which the bit-enable input is high. A new word is accepted on the same cycle its predecessor's last bit goes out, so a steady supply of words leaves no idle slot on the line.

After reset the block first sends a fixed sync header of alternating bits. Only then does it take data. A test mode replaces the external words with an internal counter that starts at zero, which lets the far end check the link. When there is nothing to send, neither wire moves.

Top module: `pair_toggle_tx`

## Requirements
- R1: A transmitted 0 toggles `wire_zero` and leaves `wire_one` unchanged; a transmitted 1 toggles `wire_one` and leaves `wire_zero` unchanged.
- R2: In any cycle at most one of the two wires changes level, so their XOR flips exactly once per transmitted bit.
- R3: A bit is sent, and the wires may change, only on the clock edge at which `bit_en` is high; each such edge sends one bit while anything is pending.
- R4: Each accepted word of WIDTH bits (default 16) is sent most significant bit first, in acceptance order.
- R5: After reset, SYNC_LEN bits (default 16) alternating 1,0,1,0,... are sent before any word. `in_ready` stays low until the edge that sends the final sync bit.
- R6: `in_ready` is high when no bits are pending, or when the last pending bit is sent on this edge. With `in_valid` and `bit_en` held high, a bit goes out on every edge from reset onward, with no gap.
- R7: When no bits are pending, neither wire changes level.
- R8: During reset both wires are low, `in_ready` is low, and the test counter returns to zero.
- R9: With `test_mode` high, the words sent are 0, 1, 2, ... counting from reset. `in_ready` is low, and `in_valid`/`in_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Send one bit on this edge if any is pending |
| test_mode | input | 1 | Take words from the internal incrementing counter |
| in_valid | input | 1 | External word offered |
| in_data | input | WIDTH | External word, sent MSB first |
| in_ready | output | 1 | External word accepted on this edge when valid |
| wire_zero | output | 1 | Toggles for each 0 bit |
| wire_one | output | 1 | Toggles for each 1 bit |

## Verification
The hardest case to reach is the hand-over of the next word on the very edge that sends the previous word's last bit. The header-to-data case, where the first word must load on the final sync bit, is the hardest of these. The stimulus holds `in_valid` and `bit_en` high from the moment reset is released and checks that every edge shows a transition. A long phase then randomises `bit_en` and `in_valid` with a fixed seed, which often stalls the enable just when one bit remains. A decoder in the bench rebuilds the bit stream from wire changes and compares it with words recorded at each observed handshake.

// File: rtl/tx2w_pkg.sv
// Package: shared types and helpers for the two-wire transition transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package tx2w_pkg;

    // Word origin selected by the test-mode input.
    typedef enum logic {
        SRC_EXT  = 1'b0,
        SRC_TEST = 1'b1
    } src_sel_e;

    // Value of the sync header bit sent while `left` bits remain.
    // An even remaining count gives 1, an odd one gives 0, so an even
    // header length starts with 1 and ends with 0.
    function automatic logic sync_bit(input logic left_lsb);
        return ~left_lsb;
    endfunction

endpackage

// File: rtl/tx2w_word_source.sv
// Module: chooses between external handshake words and an internal
// incrementing test counter, and drives the external ready.
// Assumes: slot_open comes from the shifter and is high only when the
// shifter can take a word on this edge.
module tx2w_word_source
    import tx2w_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             ext_valid,
    input  logic [WIDTH-1:0] ext_data,
    input  logic             slot_open,
    output logic             ext_ready,
    output logic             src_valid,
    output logic [WIDTH-1:0] src_data
);

    src_sel_e         sel;
    logic [WIDTH-1:0] test_count;
    logic             test_take;

    // Select the source of the next word.
    always_comb begin
        sel       = test_mode ? SRC_TEST : SRC_EXT;
        src_valid = (sel == SRC_TEST) ? 1'b1 : ext_valid;
        src_data  = (sel == SRC_TEST) ? test_count : ext_data;
        ext_ready = slot_open && (sel == SRC_EXT);
        test_take = slot_open && (sel == SRC_TEST);
    end

    // Advance the test counter each time it supplies a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_count <= '0;
        end else if (test_take) begin
            test_count <= test_count + WIDTH'(1);
        end
    end

    AST_TEST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        test_take |=> test_count == $past(test_count) + WIDTH'(1)); // R9

    AST_TEST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !test_take |=> $stable(test_count)); // R9

endmodule

// File: rtl/tx2w_shifter.sv
// Module: sends the sync header after reset, then holds each word in a
// shift register and presents one bit per enabled edge, MSB first.
// Assumes: src_valid/src_data are stable through the cycle; load happens
// on the edge that sends the last pending bit so no slot is lost.
module tx2w_shifter
    import tx2w_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int SYNC_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             src_valid,
    input  logic [WIDTH-1:0] src_data,
    output logic             slot_open,
    output logic             send,
    output logic             send_bit
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam int SW = $clog2(SYNC_LEN + 1);

    logic [WIDTH-1:0] sreg;
    logic [CW-1:0]    cnt;
    logic [SW-1:0]    sync_left;
    logic             sync_busy;
    logic             last_slot;
    logic             load;

    // Decode what goes out this cycle and whether a word may load.
    always_comb begin
        sync_busy = (sync_left != '0);
        send      = bit_en && (sync_busy || (cnt != '0));
        send_bit  = sync_busy ? sync_bit(sync_left[0]) : sreg[WIDTH-1];
        last_slot = bit_en && ((sync_left == SW'(1)) ||
                               (!sync_busy && (cnt == CW'(1))));
        slot_open = (!sync_busy && (cnt == '0)) || last_slot;
        load      = slot_open && src_valid;
    end

    // Count down the header, load words and shift out data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_left <= SW'(SYNC_LEN);
            cnt       <= '0;
            sreg      <= '0;
        end else begin
            if (send && sync_busy) begin
                sync_left <= sync_left - SW'(1);
            end
            if (load) begin
                sreg <= src_data;
                cnt  <= CW'(WIDTH);
            end else if (send && !sync_busy) begin
                sreg <= {sreg[WIDTH-2:0], 1'b0};
                cnt  <= cnt - CW'(1);
            end
        end
    end

    AST_SYNC_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (sync_left <= SW'(1))); // R5

    AST_COUNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !sync_busy && !load) |=> cnt == $past(cnt) - CW'(1)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WIDTH)); // R6

endmodule

// File: rtl/tx2w_wire_pair.sv
// Module: holds the two line levels and toggles the one selected by the
// bit being sent.
// Assumes: send is high for exactly the edges that carry a bit.
module tx2w_wire_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic send_bit,
    output logic wire_zero,
    output logic wire_one
);

    // Toggle the wire that encodes the current bit value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wire_zero <= 1'b0;
            wire_one  <= 1'b0;
        end else if (send) begin
            if (send_bit) begin
                wire_one <= ~wire_one;
            end else begin
                wire_zero <= ~wire_zero;
            end
        end
    end

    AST_ONE_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wire_zero) |-> $stable(wire_one)); // R2

    AST_QUIET_WITHOUT_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!send && rst_n) |=> ($stable(wire_zero) && $stable(wire_one))); // R7

endmodule

// File: rtl/pair_toggle_tx.sv
// Module: top of the two-wire transition transmitter; wires the word
// source, the shifter and the line pair together.
// Assumes: bit_en paces the line; the serial side is two registered levels.
module pair_toggle_tx #(
    parameter int WIDTH    = 16,
    parameter int SYNC_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             test_mode,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    output logic             wire_zero,
    output logic             wire_one
);

    logic             slot_open;
    logic             src_valid;
    logic [WIDTH-1:0] src_data;
    logic             send;
    logic             send_bit;

    tx2w_word_source #(.WIDTH(WIDTH)) u_source (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .ext_valid (in_valid),
        .ext_data  (in_data),
        .slot_open (slot_open),
        .ext_ready (in_ready),
        .src_valid (src_valid),
        .src_data  (src_data)
    );

    tx2w_shifter #(.WIDTH(WIDTH), .SYNC_LEN(SYNC_LEN)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .src_valid (src_valid),
        .src_data  (src_data),
        .slot_open (slot_open),
        .send      (send),
        .send_bit  (send_bit)
    );

    tx2w_wire_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .send_bit  (send_bit),
        .wire_zero (wire_zero),
        .wire_one  (wire_one)
    );

    AST_TEST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> !in_ready); // R9

    AST_NO_MOVE_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && rst_n) |=> ($stable(wire_zero) && $stable(wire_one))); // R3

endmodule

// File: tb/test_pair_toggle_tx.sv
// Bench: decodes the wire pair back into bits and compares them with
// the sync header plus the words seen on the handshake.
module test_pair_toggle_tx;

    localparam int WIDTH    = 16;
    localparam int SYNC_LEN = 16;
    localparam int MAXB     = 4096;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bit_en;
    logic             test_mode;
    logic             in_valid;
    logic [WIDTH-1:0] in_data;
    logic             in_ready;
    logic             wire_zero;
    logic             wire_one;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    logic exp_bits [MAXB];
    int   exp_n;
    int   rx_n;
    logic prev_zero, prev_one, prev_en;
    logic gap_watch;
    logic test_phase;

    always #2 clk = ~clk;

    pair_toggle_tx #(.WIDTH(WIDTH), .SYNC_LEN(SYNC_LEN)) i_pair_toggle_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .test_mode(test_mode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wire_zero(wire_zero), .wire_one(wire_one)
    );

    // Header bit i: alternating, first bit 1 (R5).
    function automatic logic hdr_bit(input int i);
        return (i % 2) == 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [WIDTH-1:0] w);
        for (int b = WIDTH - 1; b >= 0; b--) begin
            if (exp_n < MAXB) exp_bits[exp_n] = w[b];
            exp_n++;
        end
    endtask

    task automatic start_stream();
        exp_n = 0;
        rx_n  = 0;
        for (int i = 0; i < SYNC_LEN; i++) begin
            exp_bits[exp_n] = hdr_bit(i);
            exp_n++;
        end
        prev_zero = 1'b0;
        prev_one  = 1'b0;
    endtask

    // One clock: inputs already set at a falling edge; record handshake,
    // let the rising edge pass, then decode the wires at the next falling edge.
    task automatic step();
        logic dz, d1;
        #1;
        if (test_phase) check(in_ready == 1'b0, "R9 ready in test mode", in_ready, 0);
        else if (in_valid && in_ready) push_word(in_data);
        prev_en = bit_en;
        @(negedge clk);
        cycles++;
        dz = wire_zero ^ prev_zero;
        d1 = wire_one ^ prev_one;
        if (dz && d1) check(1'b0, "R2 both wires moved", 2, 1);
        if ((dz || d1) && !prev_en) check(1'b0, "R3 move without bit_en", 1, 0);
        if (gap_watch) check(dz || d1, "R6 gap in back-to-back stream", 0, 1);
        if ((dz ^ d1) && prev_en) begin
            if (rx_n >= exp_n) begin
                check(1'b0, "R7 transition while idle", rx_n, exp_n);
            end else if (rx_n < MAXB) begin
                check(d1 == exp_bits[rx_n],
                      rx_n < SYNC_LEN ? "R5 header bit" : "R1/R4 data bit",
                      d1, exp_bits[rx_n]);
            end
            rx_n++;
        end
        prev_zero = wire_zero;
        prev_one  = wire_one;
    endtask

    task automatic do_reset(input logic tm);
        rst_n = 1'b0; test_mode = tm; bit_en = 1'b1; in_valid = 1'b1;
        in_data = '1; gap_watch = 1'b0; test_phase = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(wire_zero == 1'b0 && wire_one == 1'b0, "R8 wires low in reset",
              {wire_zero, wire_one}, 0);
        check(in_ready == 1'b0, "R8 ready low in reset", in_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        start_stream();
    endtask

    // Watchdog: an expiry counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        prev_en = 1'b0;
        do_reset(1'b0);

        // Directed: valid and enable high from reset, no gap (R5, R6).
        bit_en = 1'b1; in_valid = 1'b1; gap_watch = 1'b1;
        for (int k = 0; k < SYNC_LEN + 8 * WIDTH; k++) begin
            in_data = WIDTH'($urandom);
            step();
        end
        check(rx_n == SYNC_LEN + 8 * WIDTH, "R6 bit count back-to-back",
              rx_n, SYNC_LEN + 8 * WIDTH);

        // Drain and idle: nothing more than what was accepted (R7).
        gap_watch = 1'b0; in_valid = 1'b0;
        for (int k = 0; k < 3 * WIDTH; k++) step();
        check(rx_n == exp_n, "R7 drained bit count", rx_n, exp_n);

        // Enable low with valid data offered: no movement (R3).
        bit_en = 1'b0; in_valid = 1'b1; in_data = 16'h8001;
        for (int k = 0; k < 10; k++) step();
        check(rx_n == exp_n - WIDTH, "R3 no bits without bit_en", rx_n, exp_n - WIDTH);

        // Random pacing and offering.
        for (int k = 0; k < 3000; k++) begin
            bit_en   = ($urandom % 3) != 0;
            in_valid = ($urandom % 4) != 0;
            in_data  = (k % 50 == 0) ? 16'h0000 : (k % 50 == 1) ? 16'hFFFF
                                                : WIDTH'($urandom);
            step();
        end
        bit_en = 1'b1; in_valid = 1'b0;
        for (int k = 0; k < 3 * WIDTH; k++) step();
        check(rx_n == exp_n, "R4 random stream length", rx_n, exp_n);

        // Test mode: counter words 0,1,2,..., external input ignored (R9).
        do_reset(1'b1);
        test_phase = 1'b1;
        for (int w = 0; w < 10; w++) push_word(WIDTH'(w));
        bit_en = 1'b1;
        for (int k = 0; k < SYNC_LEN + 6 * WIDTH; k++) begin
            in_valid = 1'b1;
            in_data  = WIDTH'($urandom);
            step();
        end
        check(rx_n == SYNC_LEN + 6 * WIDTH, "R9 test stream length",
              rx_n, SYNC_LEN + 6 * WIDTH);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule